// File: doc/BRIEF.md
# Timer Compare Output Stage with Pad Multiplexing

This block is one 16-bit timer channel. It has a free-running up-counter, two compare registers and two output pins, A and B. Each pin keeps a timer output level. Software can preset that level through a pin-control register, and a compare match can then drive it high, drive it low or toggle it. An output-enable bit gates each pin. A pad selector routes each pad to the timer level, to a general-purpose port data bit, or to nothing, in which case the pad is high-impedance. Pad tri-state is shown as a separate drive-enable output for each pad, so the block has no bidirectional port.

The channel runs in one of two modes. In normal mode, each pin follows its own compare register and the counter wraps freely. In the single-output PWM mode, pin A carries the whole waveform: compare A applies A's match action, compare B applies B's match action, and compare B also restarts the count. A synchronous register bus writes the settings, and a combinational read path returns them. This lets firmware run a fault recovery:
1. Move the pads to port data holding the safe level.
2. Stop the counter.
3. Change the mode.
4. Preset the pins again.
5. Hand the pads back to the timer and restart.

Top module: `tmr_out_stage`

Register addresses (4-bit `addr`):

| Address | Contents |
|---|---|
| 0 | Control. Bit 0 is run. Bit 1 is mode: 0 = normal, 1 = PWM. |
| 1 | Counter |
| 2 | Compare A |
| 3 | Compare B |
| 4 | Pin-control A |
| 5 | Pin-control B |
| 6 | Output enable. Bit 0 is A, bit 1 is B. |
| 7 | Pad select. Bits 1:0 are A, bits 3:2 are B. |
| 8 | Port data. Bit 0 is A, bit 1 is B. |
| 9 | Levels, read-only. Bit 0 is A, bit 1 is B. |

Any other address reads as 0.

Pin-control fields:
- Bits 1:0 set the preset: 1 = low, 2 = high, 0 or 3 = no preset.
- Bits 3:2 set the match action: 0 = hold, 1 = low, 2 = high, 3 = toggle.

Pad select codes: 1 = port, 2 = timer, 0 or 3 = off.

## Requirements
- R1: One cycle after reset, both pads are undriven (`pad_x_oe`=0, `pad_x_o`=0). Both levels read 0, the counter reads 0, the control and pin-control registers read 0, and both compares read 0xFFFF.
- R2: The counter advances by exactly one each clock while run (address 0, bit 0) is 1. While run is 0 the counter and both levels keep their values.
- R3: In normal mode the counter wraps from 0xFFFF to 0. Pin A reacts only to compare A and pin B reacts only to compare B.
- R4: A pin-control write with preset code 1 or 2 sets that pin's level on the next cycle, but only if that pin's output-enable bit is already 1. With the bit at 0, the level is unchanged.
- R5: While running, a match on the clock edge where the counter equals the compare value applies the pin's action code (hold, low, high or toggle), and the new level is visible after that edge. A preset in the same cycle overrides the action.
- R6: In PWM mode, pin A takes A's action on compare A and B's action on compare B. Compare B wins when both match. The counter goes to 0 after a compare-B match. Pin B is neither preset nor changed.
- R7: A control write made while run is 1 updates run but leaves the mode bit unchanged.
- R8: Pad select code 1 drives the port data bit. Code 2 drives the timer level only when that pin's output enable is 1 and is undriven otherwise. Codes 0 and 3 leave the pad undriven.
- R9: After the pads are diverted to the port, the counter is stopped, the mode is changed, the pins are preset again and code 2 is reselected, setting run again resumes counting and compare-driven pad output.
- R10: Every register address reads back its stored value in the field positions listed above, in the same cycle the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pad_a_o | output | 1 | Pad A drive value |
| pad_a_oe | output | 1 | Pad A drive enable (0 = high-impedance) |
| pad_b_o | output | 1 | Pad B drive value |
| pad_b_oe | output | 1 | Pad B drive enable (0 = high-impedance) |

## Verification
The checker covers these rules on every cycle:
- the counter step and its freeze;
- the PWM restart on compare B;
- the mode lock while running;
- the gating of presets by output enable;
- the frozen B level in PWM mode;
- what the pad drives for each select code.

The bench's scenarios are needed for the end-to-end matters:
- the full fault-recovery order;
- wrap-around at the top of the count;
- PWM waveform period and duty;
- readback of every field.

A bench model follows randomly interleaved register writes and reads to show these.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned DEF_CNT_W = 16;
    localparam int unsigned ADDR_W    = 4;
    localparam int unsigned NPIN      = 2;
    localparam int unsigned SEL_W     = 2;
    localparam int unsigned PC_W      = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 4'd0,
        RA_COUNT  = 4'd1,
        RA_CMPA   = 4'd2,
        RA_CMPB   = 4'd3,
        RA_PINA   = 4'd4,
        RA_PINB   = 4'd5,
        RA_OUTEN  = 4'd6,
        RA_PADSEL = 4'd7,
        RA_PORT   = 4'd8,
        RA_LEVEL  = 4'd9
    } reg_addr_e;

    typedef enum logic [1:0] {
        PRE_NONE  = 2'd0,
        PRE_LOW   = 2'd1,
        PRE_HIGH  = 2'd2,
        PRE_NONE3 = 2'd3
    } preset_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } action_e;

    typedef enum logic [SEL_W-1:0] {
        PAD_OFF   = 2'd0,
        PAD_PORT  = 2'd1,
        PAD_TIMER = 2'd2,
        PAD_OFF3  = 2'd3
    } pad_sel_e;

    typedef struct packed {
        action_e act;
        preset_e pre;
    } pin_ctrl_t;

    function automatic logic act_apply(action_e a, logic cur);
        case (a)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

    function automatic logic preset_valid(preset_e p);
        return (p == PRE_LOW) || (p == PRE_HIGH);
    endfunction

    function automatic logic preset_level(preset_e p);
        return p == PRE_HIGH;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [CNT_W-1:0]       wdata,
    input  logic [CNT_W-1:0]       cnt,
    input  logic [NPIN-1:0]        lvl,
    output logic                   run,
    output logic                   pwm,
    output logic                   cnt_wr,
    output logic [CNT_W-1:0]       cmp_a,
    output logic [CNT_W-1:0]       cmp_b,
    output pin_ctrl_t [NPIN-1:0]   pc,
    output logic [NPIN-1:0]        pc_wr,
    output logic [NPIN-1:0]        oe,
    output pad_sel_e [NPIN-1:0]    sel,
    output logic [NPIN-1:0]        port
);

    logic wr_ctrl, wr_cmpa, wr_cmpb, wr_oe, wr_sel, wr_port;

    always_comb begin
        wr_ctrl = wr_en && (addr == RA_CTRL);
        cnt_wr  = wr_en && (addr == RA_COUNT);
        wr_cmpa = wr_en && (addr == RA_CMPA);
        wr_cmpb = wr_en && (addr == RA_CMPB);
        wr_oe   = wr_en && (addr == RA_OUTEN);
        wr_sel  = wr_en && (addr == RA_PADSEL);
        wr_port = wr_en && (addr == RA_PORT);
        for (int i = 0; i < NPIN; i++) begin
            pc_wr[i] = wr_en && (addr == ADDR_W'(int'(RA_PINA) + i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            pwm   <= 1'b0;
            cmp_a <= '1;
            cmp_b <= '1;
            oe    <= '0;
            port  <= '0;
            for (int i = 0; i < NPIN; i++) begin
                pc[i]  <= '{act: ACT_HOLD, pre: PRE_NONE};
                sel[i] <= PAD_OFF;
            end
        end else begin
            if (wr_ctrl) begin
                run <= wdata[0];
                if (!run) begin
                    pwm <= wdata[1];
                end
            end
            if (wr_cmpa) cmp_a <= wdata;
            if (wr_cmpb) cmp_b <= wdata;
            if (wr_oe)   oe    <= wdata[NPIN-1:0];
            if (wr_port) port  <= wdata[NPIN-1:0];
            for (int i = 0; i < NPIN; i++) begin
                if (pc_wr[i]) pc[i]  <= pin_ctrl_t'(wdata[PC_W-1:0]);
                if (wr_sel)   sel[i] <= pad_sel_e'(wdata[SEL_W*i +: SEL_W]);
            end
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pwm,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output logic [CNT_W-1:0] cnt,
    output logic             match_a,
    output logic             match_b
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign match_a = run && (cnt == cmp_a);
    assign match_b = run && (cnt == cmp_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt_wr) begin
            cnt <= wdata;
        end else if (run) begin
            if (pwm && match_b) cnt <= '0;
            else                cnt <= cnt + ONE;
        end
    end

endmodule

// File: rtl/tmr_pin_level.sv
module tmr_pin_level
    import tmr_pkg::*;
#(
    parameter bit IS_B = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      pwm,
    input  logic      match_a,
    input  logic      match_b,
    input  pin_ctrl_t pc_own,
    input  pin_ctrl_t pc_b,
    input  logic      pre_wr,
    input  preset_e   pre_code,
    output logic      lvl
);

    logic nxt;

    generate
        if (IS_B) begin : g_pin_b
            always_comb begin
                nxt = lvl;
                if (pre_wr && !pwm && preset_valid(pre_code)) begin
                    nxt = preset_level(pre_code);
                end else if (run && !pwm && match_b) begin
                    nxt = act_apply(pc_own.act, lvl);
                end
            end
        end else begin : g_pin_a
            always_comb begin
                nxt = lvl;
                if (pre_wr && preset_valid(pre_code)) begin
                    nxt = preset_level(pre_code);
                end else if (run) begin
                    if (pwm && match_b) begin
                        nxt = act_apply(pc_b.act, lvl);
                    end else if (match_a) begin
                        nxt = act_apply(pc_own.act, lvl);
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) lvl <= 1'b0;
        else     lvl <= nxt;
    end

endmodule

// File: rtl/tmr_pad_mux.sv
module tmr_pad_mux
    import tmr_pkg::*;
(
    input  pad_sel_e sel,
    input  logic     oe,
    input  logic     port,
    input  logic     lvl,
    output logic     pad_o,
    output logic     pad_oe
);

    always_comb begin
        pad_o  = 1'b0;
        pad_oe = 1'b0;
        case (sel)
            PAD_PORT: begin
                pad_o  = port;
                pad_oe = 1'b1;
            end
            PAD_TIMER: begin
                pad_o  = oe & lvl;
                pad_oe = oe;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tmr_out_stage.sv
module tmr_out_stage
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              pad_a_o,
    output logic              pad_a_oe,
    output logic              pad_b_o,
    output logic              pad_b_oe
);

    logic                 run, pwm, cnt_wr, match_a, match_b;
    logic [CNT_W-1:0]     cnt, cmp_a, cmp_b;
    pin_ctrl_t [NPIN-1:0] pc;
    logic [NPIN-1:0]      pc_wr, oe, port, lvl, pad_o, pad_oe;
    pad_sel_e [NPIN-1:0]  sel;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt(cnt), .lvl(lvl), .run(run), .pwm(pwm), .cnt_wr(cnt_wr),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .pc(pc), .pc_wr(pc_wr), .oe(oe),
        .sel(sel), .port(port)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .pwm(pwm), .cnt_wr(cnt_wr),
        .wdata(wdata), .cmp_a(cmp_a), .cmp_b(cmp_b), .cnt(cnt),
        .match_a(match_a), .match_b(match_b)
    );

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_pin
            tmr_pin_level #(.IS_B(g == 1)) u_lvl (
                .clk(clk), .rst(rst), .run(run), .pwm(pwm),
                .match_a(match_a), .match_b(match_b),
                .pc_own(pc[g]), .pc_b(pc[1]),
                .pre_wr(pc_wr[g] & oe[g]),
                .pre_code(preset_e'(wdata[1:0])),
                .lvl(lvl[g])
            );
            tmr_pad_mux u_pad (
                .sel(sel[g]), .oe(oe[g]), .port(port[g]), .lvl(lvl[g]),
                .pad_o(pad_o[g]), .pad_oe(pad_oe[g])
            );
        end
    endgenerate

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CTRL:   rdata[1:0]      = {pwm, run};
            RA_COUNT:  rdata           = cnt;
            RA_CMPA:   rdata           = cmp_a;
            RA_CMPB:   rdata           = cmp_b;
            RA_PINA:   rdata[PC_W-1:0] = pc[0];
            RA_PINB:   rdata[PC_W-1:0] = pc[1];
            RA_OUTEN:  rdata[NPIN-1:0] = oe;
            RA_PADSEL: rdata[NPIN*SEL_W-1:0] = sel;
            RA_PORT:   rdata[NPIN-1:0] = port;
            RA_LEVEL:  rdata[NPIN-1:0] = lvl;
            default:   rdata           = '0;
        endcase
    end

    assign pad_a_o  = pad_o[0];
    assign pad_a_oe = pad_oe[0];
    assign pad_b_o  = pad_o[1];
    assign pad_b_oe = pad_oe[1];

endmodule

// File: rtl/tmr_out_stage_chk.sv
module tmr_out_stage_chk
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic                 run,
    input logic                 pwm,
    input logic                 cnt_wr,
    input logic [CNT_W-1:0]     cnt,
    input logic [CNT_W-1:0]     cmp_b,
    input logic [NPIN-1:0]      pc_wr,
    input logic [NPIN-1:0]      oe,
    input logic [NPIN-1:0]      lvl,
    input logic [NPIN-1:0]      port,
    input pad_sel_e [NPIN-1:0]  sel,
    input logic                 pad_a_o,
    input logic                 pad_a_oe,
    input logic                 pad_b_oe
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assert_reset_pads_R1: assert property (@(posedge clk)
        rst |=> (!pad_a_oe && !pad_b_oe && lvl == '0));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !pwm && !cnt_wr) |=> (cnt == $past(cnt) + ONE));

    assert_count_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr && pc_wr == '0) |=> ($stable(cnt) && $stable(lvl)));

    assert_preset_gated_R4: assert property (@(posedge clk) disable iff (rst)
        (!run && pc_wr[0] && !oe[0]) |=> $stable(lvl[0]));

    assert_pwm_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (run && pwm && !cnt_wr && cnt == cmp_b) |=> (cnt == '0));

    assert_pwm_b_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        pwm |=> $stable(lvl[1]));

    assert_mode_lock_R7: assert property (@(posedge clk) disable iff (rst)
        (run && wr_en && addr == RA_CTRL) |=> $stable(pwm));

    assert_port_pad_R8: assert property (@(posedge clk) disable iff (rst)
        (sel[0] == PAD_PORT) |-> (pad_a_oe && pad_a_o == port[0]));

    assert_gated_pad_R8: assert property (@(posedge clk) disable iff (rst)
        (sel[0] != PAD_PORT && !oe[0]) |-> !pad_a_oe);

endmodule

bind tmr_out_stage tmr_out_stage_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .run(run), .pwm(pwm),
    .cnt_wr(cnt_wr), .cnt(cnt), .cmp_b(cmp_b), .pc_wr(pc_wr), .oe(oe),
    .lvl(lvl), .port(port), .sel(sel), .pad_a_o(pad_a_o),
    .pad_a_oe(pad_a_oe), .pad_b_oe(pad_b_oe)
);

// File: tb/tmr_out_stage_bench.sv
`timescale 1ns/1ps
module tmr_out_stage_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        pad_a_o, pad_a_oe, pad_b_o, pad_b_oe;

    int unsigned vectors = 0;
    int unsigned miscompares = 0;
    bit          done = 1'b0;

    // bench model state
    logic        m_run, m_pwm;
    logic [15:0] m_cnt, m_cmpa, m_cmpb;
    logic [3:0]  m_pca, m_pcb, m_sel;
    logic [1:0]  m_oe, m_port, m_lvl;

    tmr_out_stage u_tmr_out_stage (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_a_o(pad_a_o), .pad_a_oe(pad_a_oe),
        .pad_b_o(pad_b_o), .pad_b_oe(pad_b_oe)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic b_act(input logic [1:0] a, input logic cur);
        case (a)
            2'd1: return 1'b0;
            2'd2: return 1'b1;
            2'd3: return ~cur;
            default: return cur;
        endcase
    endfunction

    function automatic logic [15:0] model_read(input logic [3:0] a);
        case (a)
            4'd0: return {14'd0, m_pwm, m_run};
            4'd1: return m_cnt;
            4'd2: return m_cmpa;
            4'd3: return m_cmpb;
            4'd4: return {12'd0, m_pca};
            4'd5: return {12'd0, m_pcb};
            4'd6: return {14'd0, m_oe};
            4'd7: return {12'd0, m_sel};
            4'd8: return {14'd0, m_port};
            4'd9: return {14'd0, m_lvl};
            default: return 16'd0;
        endcase
    endfunction

    function automatic logic [1:0] pad_of(input logic [1:0] s, input logic o,
                                          input logic p, input logic l);
        case (s)
            2'd1: return {1'b1, p};
            2'd2: return o ? {1'b1, l} : 2'b00;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [3:0] model_pads();
        return {pad_of(m_sel[1:0], m_oe[0], m_port[0], m_lvl[0]),
                pad_of(m_sel[3:2], m_oe[1], m_port[1], m_lvl[1])};
    endfunction

    task automatic model_reset();
        m_run = 0; m_pwm = 0; m_cnt = 0; m_cmpa = 16'hFFFF; m_cmpb = 16'hFFFF;
        m_pca = 0; m_pcb = 0; m_sel = 0; m_oe = 0; m_port = 0; m_lvl = 0;
    endtask

    task automatic model_advance(input logic we, input logic [3:0] a, input logic [15:0] d);
        logic ma, mb, n0, n1;
        logic [15:0] nc;
        logic pre_ok;
        ma = m_run && (m_cnt == m_cmpa);
        mb = m_run && (m_cnt == m_cmpb);
        pre_ok = (d[1:0] == 2'd1) || (d[1:0] == 2'd2);
        n0 = m_lvl[0];
        n1 = m_lvl[1];
        if (we && a == 4'd4 && m_oe[0] && pre_ok) n0 = (d[1:0] == 2'd2);
        else if (m_run) begin
            if (m_pwm && mb)  n0 = b_act(m_pcb[3:2], m_lvl[0]);
            else if (ma)      n0 = b_act(m_pca[3:2], m_lvl[0]);
        end
        if (we && a == 4'd5 && m_oe[1] && !m_pwm && pre_ok) n1 = (d[1:0] == 2'd2);
        else if (m_run && !m_pwm && mb) n1 = b_act(m_pcb[3:2], m_lvl[1]);
        nc = m_cnt;
        if (we && a == 4'd1) nc = d;
        else if (m_run) nc = (m_pwm && mb) ? 16'd0 : m_cnt + 16'd1;
        if (we) begin
            case (a)
                4'd0: begin
                    if (!m_run) m_pwm = d[1];
                    m_run = d[0];
                end
                4'd2: m_cmpa = d;
                4'd3: m_cmpb = d;
                4'd4: m_pca = d[3:0];
                4'd5: m_pcb = d[3:0];
                4'd6: m_oe = d[1:0];
                4'd7: m_sel = d[3:0];
                4'd8: m_port = d[1:0];
                default: ;
            endcase
        end
        m_lvl = {n1, n0};
        m_cnt = nc;
    endtask

    task automatic step(input logic we, input logic [3:0] a, input logic [15:0] d,
                        input string tag);
        @(negedge clk);
        wr_en = we;
        addr  = a;
        wdata = d;
        #1;
        if (!we) check(tag, "rdata", {16'd0, rdata}, {16'd0, model_read(a)});
        @(posedge clk);
        model_advance(we, a, d);
        #1;
        check(tag, "pads", {28'd0, pad_a_oe, pad_a_o, pad_b_oe, pad_b_o},
              {28'd0, model_pads()});
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input string tag);
        step(1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        step(1'b0, a, 16'd0, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "pad_a_oe", {31'd0, pad_a_oe}, 32'd0);
        check("R1", "pad_b_oe", {31'd0, pad_b_oe}, 32'd0);
        for (int a = 0; a < 11; a++) rd(4'(a), "R1");

        // R4: preset gated by output enable
        wr(4'd4, 16'h0006, "R4");
        rd(4'd9, "R4");
        check("R4", "level A gated", {31'd0, rdata[0]}, 32'd0);
        wr(4'd6, 16'h0003, "R4");
        wr(4'd4, 16'h0006, "R4");
        rd(4'd9, "R4");
        check("R4", "level A preset", {31'd0, rdata[0]}, 32'd1);

        // R8: timer function on pad A with enable on
        wr(4'd7, 16'h0002, "R8");
        check("R8", "pad A timer", {30'd0, pad_a_oe, pad_a_o}, 32'd3);
        wr(4'd6, 16'h0002, "R8");
        check("R8", "pad A timer disabled", {31'd0, pad_a_oe}, 32'd0);
        wr(4'd7, 16'h000F, "R8");
        wr(4'd6, 16'h0003, "R8");

        // R6: PWM mode, B pin not preset
        wr(4'd0, 16'h0002, "R6");
        wr(4'd4, 16'h0006, "R6");
        wr(4'd5, 16'h0002, "R6");
        wr(4'd2, 16'd3, "R6");
        wr(4'd3, 16'd7, "R6");
        wr(4'd5, 16'h0008, "R6");
        wr(4'd7, 16'h000A, "R6");
        rd(4'd9, "R6");
        check("R6", "B not preset", {31'd0, rdata[1]}, 32'd0);
        wr(4'd0, 16'h0003, "R6");
        for (int i = 0; i < 24; i++) rd((i % 2 == 0) ? 4'd1 : 4'd9, "R6");

        // R7 and R9: recovery sequence
        wr(4'd8, 16'h0001, "R9");
        wr(4'd7, 16'h0005, "R9");
        check("R9", "pad A safe level", {30'd0, pad_a_oe, pad_a_o}, 32'd3);
        wr(4'd0, 16'h0000, "R7");
        rd(4'd0, "R7");
        check("R7", "mode kept", {30'd0, rdata[1:0]}, 32'd2);
        rd(4'd1, "R2");
        rd(4'd1, "R2");
        wr(4'd0, 16'h0000, "R9");
        wr(4'd1, 16'd0, "R9");
        wr(4'd4, 16'h0006, "R9");
        wr(4'd5, 16'h0009, "R9");
        wr(4'd7, 16'h000A, "R9");
        wr(4'd0, 16'h0001, "R9");
        for (int i = 0; i < 12; i++) rd(4'd9, "R9");
        rd(4'd0, "R9");
        check("R9", "normal mode running", {30'd0, rdata[1:0]}, 32'd1);

        // R3: wrap at the top of the count, R5 toggle on B
        wr(4'd5, 16'h000C, "R5");
        wr(4'd3, 16'h0001, "R5");
        wr(4'd1, 16'hFFFD, "R3");
        for (int i = 0; i < 6; i++) rd(4'd1, "R3");
        wr(4'd0, 16'h0000, "R2");
        for (int i = 0; i < 4; i++) rd(4'd1, "R2");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int unsigned op, sel_a;
            logic [15:0] d;
            op = $urandom_range(0, 99);
            if (op < 45) begin
                rd(4'($urandom_range(0, 10)), "R10");
            end else begin
                sel_a = $urandom_range(0, 8);
                case (sel_a)
                    0: d = 16'($urandom_range(0, 3));
                    1, 2, 3: d = ($urandom_range(0, 9) == 0) ?
                                 16'(16'hFFF8 + $urandom_range(0, 7)) :
                                 16'($urandom_range(0, 20));
                    default: d = 16'($urandom_range(0, 15));
                endcase
                if (sel_a == 0 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
                wr(4'(sel_a), d, "R5");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            miscompares++;
            $display("FAIL R2 watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule